// File: doc/BRIEF.md
# Regulator Power-Good and Fault Supervisor

This block is the digital supervisor that sits beside the PWM core of a step-down regulator. Analog comparators outside it reduce the output and control voltages to single-bit flags: output inside the ±4% regulation window, output above 115% of setpoint, enable pin above its 2.0 V level, enable pin above its 1.7 V level, and undervoltage lockout on the logic rail (below 4.0 V) and on the gate-driver rail (below 9.0 V). The supervisor turns these flags into system status and into one inhibit line for the gate drivers.

Power-good needs a long run of in-window samples to rise and a shorter run of out-of-window samples to fall. Every qualification time is a parameter counted in clock ticks, and any break in a condition restarts its count from zero. A sustained overvoltage sets a sticky fault. A sustained low enable level sets a sticky shutdown. Both stay set until reset or until the enable input is driven low and then high again. While either is set, or either supply rail is in lockout, the gates are inhibited.

Top module: `pwr_supervisor`

## Requirements
- R1: During and after reset, `pgood`, `ov_fault`, `shutdown` and `ot_warn` are 0.
- R2: `pgood` goes to 1 on the clock edge after `in_window` has been 1 at PG_RISE_TICKS consecutive clock edges, provided neither latch is set.
- R3: `pgood` goes to 0 on the clock edge after `in_window` has been 0 at PG_FALL_TICKS consecutive clock edges. Otherwise it holds its value.
- R4: Each qualification count (in-window, out-of-window, overvoltage, low enable) restarts from zero whenever its condition is absent at a clock edge. A run one edge short of its limit therefore has no effect.
- R5: `ov_fault` is set on the edge after `over_volt` has been 1 at OV_TICKS consecutive edges. It stays set after `over_volt` returns to 0.
- R6: A set latch (`ov_fault` or `shutdown`) is cleared by reset, or on the edge where `en_hi` is sampled 1 after being sampled 0 at the previous edge.
- R7: `ot_warn` is the inverse of `en_hi` as sampled at the previous clock edge.
- R8: `shutdown` is set on the edge after `en_lo` has been 0 at SD_TICKS consecutive edges. It stays set after `en_lo` returns to 1.
- R9: `gate_inhibit` is 1, with no clock delay, whenever `logic_uv`, `drv_uv`, `ov_fault` or `shutdown` is 1. It is 0 otherwise.
- R10: While `ov_fault` or `shutdown` is set, `pgood` is forced to 0 at the next edge and held there.
- R11: If a latch's set condition is met on the same edge as an enable rising edge, the latch stays set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_window | input | 1 | Output is within ±4% of setpoint |
| over_volt | input | 1 | Output is above 115% of setpoint |
| en_hi | input | 1 | Enable pin above 2.0 V (logic enable) |
| en_lo | input | 1 | Enable pin above 1.7 V |
| logic_uv | input | 1 | Logic rail below 4.0 V |
| drv_uv | input | 1 | Driver rail below 9.0 V |
| pgood | output | 1 | Output regulated and qualified |
| ov_fault | output | 1 | Sticky overvoltage fault |
| ot_warn | output | 1 | Over-temperature warning |
| shutdown | output | 1 | Sticky thermal shutdown |
| gate_inhibit | output | 1 | Forces both gate outputs off |

## Verification
The bench targets runs that stop one edge short of a limit, and runs broken by a single-cycle glitch. A counter that fails to restart would let these qualify early and raise `pgood` or a latch too soon. It holds `over_volt` high while toggling the enable input. A design that gives the clear priority would drop the fault for a cycle while the overvoltage is still present. It checks that `ov_fault` and `shutdown` persist after their causes go away and that `pgood` stays low under them. A non-sticky latch or a missing block on power-good would show up there. It also checks that `gate_inhibit` tracks each lockout flag in the same cycle.

// File: rtl/pwr_sup_pkg.sv
package pwr_sup_pkg;

  // Next power-good value: blocking wins, then rise, then fall, else hold.
  function automatic logic pg_step(input logic cur, input logic blk,
                                   input logic rise, input logic fall);
    if (blk)       return 1'b0;
    else if (rise) return 1'b1;
    else if (fall) return 1'b0;
    else           return cur;
  endfunction

  // Sticky latch update: set has priority over clear.
  function automatic logic sticky_step(input logic cur, input logic set,
                                       input logic clr);
    if (set)      return 1'b1;
    else if (clr) return 1'b0;
    else          return cur;
  endfunction

endpackage

// File: rtl/qual_timer.sv
module qual_timer #(
  parameter int TICKS = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cond,
  output logic done
);
  localparam int CW = (TICKS < 2) ? 1 : $clog2(TICKS + 1);
  localparam logic [CW-1:0] LIM = CW'(TICKS);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  always_comb begin
    if (!cond)           cnt_d = '0;
    else if (cnt_q == LIM) cnt_d = cnt_q;
    else                 cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign done = (cnt_q == LIM);
endmodule

// File: rtl/sticky_latch.sv
module sticky_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q
);
  import pwr_sup_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= sticky_step(q, set, clr);
  end
endmodule

// File: rtl/pwr_supervisor.sv
module pwr_supervisor #(
  parameter int PG_RISE_TICKS = 400,
  parameter int PG_FALL_TICKS = 100,
  parameter int OV_TICKS      = 100,
  parameter int SD_TICKS      = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_window,
  input  logic over_volt,
  input  logic en_hi,
  input  logic en_lo,
  input  logic logic_uv,
  input  logic drv_uv,
  output logic pgood,
  output logic ov_fault,
  output logic ot_warn,
  output logic shutdown,
  output logic gate_inhibit
);
  import pwr_sup_pkg::*;

  // Named internal events
  logic rise_ok, fall_ok, ov_set, sd_set, clr_ev, blk;
  logic en_q, pg_q, ot_q;

  qual_timer #(.TICKS(PG_RISE_TICKS)) u_rise (
    .clk(clk), .rst_n(rst_n), .cond(in_window),  .done(rise_ok));
  qual_timer #(.TICKS(PG_FALL_TICKS)) u_fall (
    .clk(clk), .rst_n(rst_n), .cond(!in_window), .done(fall_ok));
  qual_timer #(.TICKS(OV_TICKS)) u_ov (
    .clk(clk), .rst_n(rst_n), .cond(over_volt),  .done(ov_set));
  qual_timer #(.TICKS(SD_TICKS)) u_sd (
    .clk(clk), .rst_n(rst_n), .cond(!en_lo),     .done(sd_set));

  assign clr_ev = en_hi & ~en_q;

  sticky_latch u_ov_latch (
    .clk(clk), .rst_n(rst_n), .set(ov_set), .clr(clr_ev), .q(ov_fault));
  sticky_latch u_sd_latch (
    .clk(clk), .rst_n(rst_n), .set(sd_set), .clr(clr_ev), .q(shutdown));

  assign blk = ov_fault | shutdown;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0;
      pg_q <= 1'b0;
      ot_q <= 1'b0;
    end else begin
      en_q <= en_hi;
      pg_q <= pg_step(pg_q, blk, rise_ok, fall_ok);
      ot_q <= ~en_hi;
    end
  end

  assign pgood        = pg_q;
  assign ot_warn      = ot_q;
  assign gate_inhibit = logic_uv | drv_uv | blk;
endmodule

// File: rtl/pwr_supervisor_chk.sv
module pwr_supervisor_chk (
  input logic clk,
  input logic rst_n,
  input logic en_hi,
  input logic logic_uv,
  input logic drv_uv,
  input logic pgood,
  input logic ov_fault,
  input logic ot_warn,
  input logic shutdown,
  input logic gate_inhibit,
  input logic rise_ok,
  input logic fall_ok,
  input logic clr_ev
);
  assert_pg_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pgood) |-> $past(rise_ok));

  assert_pg_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pgood) |-> $past(fall_ok || ov_fault || shutdown));

  assert_ov_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ov_fault) |-> $past(clr_ev));

  assert_sd_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(shutdown) |-> $past(clr_ev));

  assert_ot_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ot_warn) |-> $past(!en_hi));

  assert_ot_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ot_warn) |-> $past(en_hi));

  assert_inhibit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ov_fault || shutdown || logic_uv || drv_uv) |-> gate_inhibit);

  assert_block_pg_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ov_fault || shutdown) |=> !pgood);
endmodule

bind pwr_supervisor pwr_supervisor_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en_hi(en_hi), .logic_uv(logic_uv),
  .drv_uv(drv_uv), .pgood(pgood), .ov_fault(ov_fault), .ot_warn(ot_warn),
  .shutdown(shutdown), .gate_inhibit(gate_inhibit), .rise_ok(rise_ok),
  .fall_ok(fall_ok), .clr_ev(clr_ev));

// File: tb/pwr_supervisor_tb.sv
`timescale 1ns/1ps
module pwr_supervisor_tb;
  localparam int RISE = 40, FALL = 10, OVT = 10, SDT = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_window = 0, over_volt = 0, en_hi = 1, en_lo = 1;
  logic logic_uv = 1, drv_uv = 1;
  logic pgood, ov_fault, ot_warn, shutdown, gate_inhibit;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done_flag = 0;

  always #2.5 clk = ~clk;

  pwr_supervisor #(.PG_RISE_TICKS(RISE), .PG_FALL_TICKS(FALL),
                   .OV_TICKS(OVT), .SD_TICKS(SDT)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_window(in_window), .over_volt(over_volt),
    .en_hi(en_hi), .en_lo(en_lo), .logic_uv(logic_uv), .drv_uv(drv_uv),
    .pgood(pgood), .ov_fault(ov_fault), .ot_warn(ot_warn),
    .shutdown(shutdown), .gate_inhibit(gate_inhibit));

  // Behavioural reference: run lengths and sticky flags
  int run_in = 0, run_out = 0, run_ov = 0, run_sd = 0;
  bit m_pg = 0, m_fault = 0, m_sd = 0, m_ot = 0, m_en_prev = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_in = 0; run_out = 0; run_ov = 0; run_sd = 0;
      m_pg = 0; m_fault = 0; m_sd = 0; m_ot = 0; m_en_prev = 0;
    end else begin
      bit rise_en;
      bit blocked;
      rise_en = en_hi && !m_en_prev;
      blocked = m_fault || m_sd;
      if (blocked) m_pg = 0;
      else if (run_in >= RISE) m_pg = 1;
      else if (run_out >= FALL) m_pg = 0;
      if (run_ov >= OVT) m_fault = 1; else if (rise_en) m_fault = 0;
      if (run_sd >= SDT) m_sd = 1;    else if (rise_en) m_sd = 0;
      m_ot = !en_hi;
      m_en_prev = en_hi;
      run_in  = in_window  ? run_in + 1  : 0;
      run_out = !in_window ? run_out + 1 : 0;
      run_ov  = over_volt  ? run_ov + 1  : 0;
      run_sd  = !en_lo     ? run_sd + 1  : 0;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Cycle-by-cycle comparison against the reference
  always @(negedge clk) if (!done_flag) begin
    check(pgood == m_pg, "R2/R3 pgood vs model", pgood, m_pg);
    check(ov_fault == m_fault, "R5 ov_fault vs model", ov_fault, m_fault);
    check(ot_warn == m_ot, "R7 ot_warn vs model", ot_warn, m_ot);
    check(shutdown == m_sd, "R8 shutdown vs model", shutdown, m_sd);
    check(gate_inhibit == (logic_uv | drv_uv | m_fault | m_sd),
          "R9 gate_inhibit vs model", gate_inhibit,
          int'(logic_uv | drv_uv | m_fault | m_sd));
  end

  task automatic finish_run();
    done_flag = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      finish_run();
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic probe(input logic v, input logic e, input string req);
    @(negedge clk);
    check(v === e, req, v, e);
  endtask

  initial begin
    step(3);
    @(negedge clk);
    check(pgood == 0 && ov_fault == 0 && shutdown == 0 && ot_warn == 0,
          "R1 reset outputs low", {pgood, ov_fault, shutdown, ot_warn}, 0);
    step(0); @(posedge clk); #1 rst_n = 1;
    step(2);
    @(negedge clk); check(ot_warn == 0, "R1 ot_warn after reset", ot_warn, 0);
    // R9: lockout flags one at a time
    step(0); @(posedge clk); #1 logic_uv = 0;
    @(negedge clk); check(gate_inhibit == 1, "R9 drv_uv alone inhibits", gate_inhibit, 1);
    @(posedge clk); #1 drv_uv = 0;
    @(negedge clk); check(gate_inhibit == 0, "R9 both rails ok", gate_inhibit, 0);
    @(posedge clk); #1 logic_uv = 1;
    @(negedge clk); check(gate_inhibit == 1, "R9 logic_uv inhibits", gate_inhibit, 1);
    @(posedge clk); #1 logic_uv = 0;

    // R2: exact rise timing
    in_window = 1;
    repeat (RISE) @(posedge clk);
    @(negedge clk); check(pgood == 0, "R2 pgood not yet", pgood, 0);
    @(negedge clk); check(pgood == 1, "R2 pgood rises", pgood, 1);
    // R4: short dip does not drop pgood
    @(posedge clk); #1 in_window = 0;
    step(FALL - 1); in_window = 1;
    step(2); probe(pgood, 1'b1, "R4 short dip ignored");
    // R3: long dip drops it
    @(posedge clk); #1 in_window = 0;
    step(FALL + 2); probe(pgood, 1'b0, "R3 pgood falls");
    // R4: interrupted rise restarts
    @(posedge clk); #1 in_window = 1;
    step(RISE - 5); in_window = 0;
    step(1); in_window = 1;
    step(RISE - 5); probe(pgood, 1'b0, "R4 rise restarted");
    step(10); probe(pgood, 1'b1, "R2 pgood after restart");

    // R4/R5: short overvoltage then a qualifying one
    @(posedge clk); #1 over_volt = 1;
    step(OVT - 1); over_volt = 0;
    step(2); probe(ov_fault, 1'b0, "R4 short overvoltage ignored");
    @(posedge clk); #1 over_volt = 1;
    step(OVT + 2); probe(ov_fault, 1'b1, "R5 fault set");
    probe(pgood, 1'b0, "R10 pgood blocked by fault");
    probe(gate_inhibit, 1'b1, "R9 fault inhibits");
    // R11: toggle enable while overvoltage persists
    @(posedge clk); #1 en_hi = 0;
    step(1); probe(ot_warn, 1'b1, "R7 warning on low enable");
    @(posedge clk); #1 en_hi = 1;
    step(1); probe(ov_fault, 1'b1, "R11 set wins over clear");
    probe(ot_warn, 1'b0, "R7 warning clears");
    @(posedge clk); #1 over_volt = 0;
    step(20); probe(ov_fault, 1'b1, "R5 fault sticky");
    probe(pgood, 1'b0, "R10 pgood held low");
    // R6: enable toggle clears
    @(posedge clk); #1 en_hi = 0;
    step(2); en_hi = 1;
    step(1); probe(ov_fault, 1'b0, "R6 toggle clears fault");
    step(RISE + 2); probe(pgood, 1'b1, "R2 pgood recovers");

    // R8: low enable level
    @(posedge clk); #1 en_hi = 0; en_lo = 0;
    step(SDT - 1); en_lo = 1;
    step(2); probe(shutdown, 1'b0, "R4 short low enable ignored");
    @(posedge clk); #1 en_lo = 0;
    step(SDT + 2); probe(shutdown, 1'b1, "R8 shutdown set");
    probe(gate_inhibit, 1'b1, "R9 shutdown inhibits");
    @(posedge clk); #1 en_lo = 1;
    step(10); probe(shutdown, 1'b1, "R8 shutdown sticky");
    probe(pgood, 1'b0, "R10 pgood blocked by shutdown");
    @(posedge clk); #1 en_hi = 1;
    step(1); probe(shutdown, 1'b0, "R6 toggle clears shutdown");

    // R6: reset clears a set fault
    @(posedge clk); #1 over_volt = 1;
    step(OVT + 2); over_volt = 0;
    probe(ov_fault, 1'b1, "R5 fault set again");
    @(posedge clk); #1 rst_n = 0;
    step(1); probe(ov_fault, 1'b0, "R6 reset clears fault");
    rst_n = 1;
    step(5);
    finish_run();
  end
endmodule